// File: doc/BRIEF.md
# Segment Limit and Privilege Checker

This block checks one memory access against a segment whose descriptor fields are already cached next to it. Each request gives the segment's base, 20-bit limit, privilege level, type and control flags. It also gives the requester's privilege level, a 32-bit offset, the access length and the kind of access: read, write or instruction fetch. One clock edge later the block returns the 32-bit linear address and a single verdict. The verdict is one of: granted, limit fault, type fault or privilege fault.

The block scales the limit by the granularity flag. It supports data segments that grow downward and applies the per-segment write and read permissions. For flat 64-bit code segments it skips the base and the limit. It sits between address generation and paging. Descriptor fetch and translation past the linear address happen elsewhere.

Top module: `seg_guard`

## Requirements
- R1: Outputs are registered. `out_valid` equals `req_valid` from the previous clock edge. `out_linear` and `out_verdict` update only on edges where `req_valid` is 1. Synchronous reset clears `out_valid`, `out_linear` and `out_verdict` to 0.
- R2: The linear address is `seg_base` plus the effective offset, modulo 2^32. Any byte alignment of the base is allowed.
- R3: When `seg_def32` is 0 (and the segment is not flat code), only offset bits 15:0 are used and bits 31:16 have no effect. When `seg_def32` is 1, all 32 bits are used.
- R4: When `seg_gran` is 0, the effective limit equals `seg_limit`. When it is 1, the effective limit is `{seg_limit, 12'hFFF}`.
- R5: For a segment that grows upward, the last byte (offset + `req_len_m1`) must not exceed the effective limit. A carry out of bit 31 of that sum also gives verdict 1 (limit fault).
- R6: For a data segment with `seg_down`=1, valid last bytes run up to FFFFH when `seg_def32`=0, or up to FFFFFFFFH when it is 1. An offset at or below the effective limit gives verdict 1.
- R7: If `req_rpl` is numerically greater than `seg_dpl`, the verdict is 3 (privilege fault). Equal or lower values pass this check.
- R8: The following give verdict 2 (type fault): a write to a code segment, a read of a code segment whose `seg_rw` is 0, a write to a data segment whose `seg_rw` is 0, and a fetch from a data segment. `req_kind` encodes read as 0, write as 1 and fetch as 2; the value 3 is treated as a read.
- R9: A code segment with `seg_long`=1 uses a zero base and the full 32-bit offset, and it has no limit check. `seg_long` has no effect on data segments.
- R10: The verdict encoding is 0 granted, 1 limit, 2 type, 3 privilege. When several faults apply, privilege wins over type, and type wins over limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| seg_base | input | 32 | Cached segment base |
| seg_limit | input | 20 | Cached limit field (last valid offset, before scaling) |
| seg_dpl | input | 2 | Segment privilege level |
| seg_is_code | input | 1 | 1 = code segment, 0 = data segment |
| seg_rw | input | 1 | Code: readable; data: writable |
| seg_down | input | 1 | Data segment grows downward |
| seg_gran | input | 1 | Limit counted in 4 KiB units |
| seg_def32 | input | 1 | 32-bit default offset width |
| seg_long | input | 1 | Flat 64-bit code segment |
| req_rpl | input | 2 | Requested privilege level |
| req_offset | input | 32 | Offset within the segment |
| req_len_m1 | input | 2 | Access length in bytes minus one |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| out_valid | output | 1 | Result present |
| out_linear | output | 32 | Linear address |
| out_verdict | output | 2 | 0 ok, 1 limit, 2 type, 3 privilege |

## Verification
The bench goes after the exact limit edges. It tries a last byte equal to the limit and one byte past it, multi-byte accesses that straddle the limit, and the 4 KiB-scaled limit with its filled low bits. A design that tests the first byte instead of the last, or that pads the scaled limit with zeros, grants or faults one step off. Downward-growing segments are probed at limit, limit+1 and the 16-bit ceiling. An inverted comparison there would grant exactly the offsets that must fault. Further cases cover offset wrap past 2^32, masking of the high offset half, the flat code bypass and stacked faults. These catch a lost carry, a missing 16-bit mask, a bypass that keeps the base, and a wrong fault priority.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    VERD_OK    = 2'd0,
    VERD_LIMIT = 2'd1,
    VERD_TYPE  = 2'd2,
    VERD_PRIV  = 2'd3
  } verdict_e;
endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
  parameter int ADDR_W  = 32,
  parameter int LIM_W   = 20,
  parameter int LEN_W   = 2,
  parameter int SHORT_W = 16
) (
  input  logic [ADDR_W-1:0] eff_off,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [LIM_W-1:0]  lim_field,
  input  logic              gran,
  input  logic              grows_down,
  input  logic              def32,
  input  logic              bypass,
  output logic              limit_fault
);
  localparam int GRAN_SH = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] eff_lim;
  logic [ADDR_W:0]   last_ext;
  logic [ADDR_W-1:0] last_byte;
  logic [ADDR_W-1:0] down_ceiling;
  logic              carry;
  logic              up_fault;
  logic              dn_fault;

  always_comb begin
    if (gran) eff_lim = {lim_field, {GRAN_SH{1'b1}}};
    else      eff_lim = {{GRAN_SH{1'b0}}, lim_field};

    last_ext  = {1'b0, eff_off} + {{(ADDR_W+1-LEN_W){1'b0}}, len_m1};
    carry     = last_ext[ADDR_W];
    last_byte = last_ext[ADDR_W-1:0];

    if (def32) down_ceiling = {ADDR_W{1'b1}};
    else       down_ceiling = {{(ADDR_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    up_fault = carry || (last_byte > eff_lim);
    dn_fault = carry || (eff_off <= eff_lim) || (last_byte > down_ceiling);

    limit_fault = !bypass && (grows_down ? dn_fault : up_fault);
  end
endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
  import seg_guard_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] rpl,
  input  logic [PL_W-1:0] dpl,
  input  logic            is_code,
  input  logic            rw_ok,
  input  logic [1:0]      kind,
  output logic            priv_fault,
  output logic            type_fault
);
  always_comb begin
    priv_fault = (rpl > dpl);
    type_fault = 1'b0;
    if (is_code) begin
      case (kind)
        KIND_WRITE: type_fault = 1'b1;
        KIND_FETCH: type_fault = 1'b0;
        default:    type_fault = !rw_ok;
      endcase
    end else begin
      case (kind)
        KIND_WRITE: type_fault = !rw_ok;
        KIND_FETCH: type_fault = 1'b1;
        default:    type_fault = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIM_W   = 20,
  parameter int LEN_W   = 2,
  parameter int PL_W    = 2,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [LIM_W-1:0]  seg_limit,
  input  logic [PL_W-1:0]   seg_dpl,
  input  logic              seg_is_code,
  input  logic              seg_rw,
  input  logic              seg_down,
  input  logic              seg_gran,
  input  logic              seg_def32,
  input  logic              seg_long,
  input  logic [PL_W-1:0]   req_rpl,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic [1:0]        req_kind,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_linear,
  output logic [1:0]        out_verdict
);
  localparam int HI_W = ADDR_W - SHORT_W;

  logic              flat_code;
  logic              grows_down;
  logic              wide_off;
  logic [ADDR_W-1:0] eff_off;
  logic [ADDR_W-1:0] linear_nxt;
  logic              limit_fault;
  logic              priv_fault;
  logic              type_fault;
  verdict_e          verdict_nxt;

  assign flat_code  = seg_is_code && seg_long;
  assign grows_down = !seg_is_code && seg_down;
  assign wide_off   = seg_def32 || flat_code;

  generate
    if (HI_W > 0) begin : g_mask
      assign eff_off = wide_off ? req_offset
                                : {{HI_W{1'b0}}, req_offset[SHORT_W-1:0]};
    end else begin : g_nomask
      assign eff_off = req_offset;
    end
  endgenerate

  assign linear_nxt = flat_code ? eff_off : (seg_base + eff_off);

  seg_limit_unit #(
    .ADDR_W (ADDR_W),
    .LIM_W  (LIM_W),
    .LEN_W  (LEN_W),
    .SHORT_W(SHORT_W)
  ) limit_i (
    .eff_off    (eff_off),
    .len_m1     (req_len_m1),
    .lim_field  (seg_limit),
    .gran       (seg_gran),
    .grows_down (grows_down),
    .def32      (seg_def32),
    .bypass     (flat_code),
    .limit_fault(limit_fault)
  );

  seg_rights_unit #(
    .PL_W(PL_W)
  ) rights_i (
    .rpl       (req_rpl),
    .dpl       (seg_dpl),
    .is_code   (seg_is_code),
    .rw_ok     (seg_rw),
    .kind      (req_kind),
    .priv_fault(priv_fault),
    .type_fault(type_fault)
  );

  always_comb begin
    if (priv_fault)       verdict_nxt = VERD_PRIV;
    else if (type_fault)  verdict_nxt = VERD_TYPE;
    else if (limit_fault) verdict_nxt = VERD_LIMIT;
    else                  verdict_nxt = VERD_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_linear  <= '0;
      out_verdict <= VERD_OK;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_linear  <= linear_nxt;
        out_verdict <= verdict_nxt;
      end
    end
  end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int ADDR_W  = 32,
  parameter int LIM_W   = 20,
  parameter int LEN_W   = 2,
  parameter int PL_W    = 2,
  parameter int SHORT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] seg_base,
  input logic [LIM_W-1:0]  seg_limit,
  input logic [PL_W-1:0]   seg_dpl,
  input logic              seg_is_code,
  input logic              seg_rw,
  input logic              seg_down,
  input logic              seg_gran,
  input logic              seg_def32,
  input logic              seg_long,
  input logic [PL_W-1:0]   req_rpl,
  input logic [ADDR_W-1:0] req_offset,
  input logic [LEN_W-1:0]  req_len_m1,
  input logic [1:0]        req_kind,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_linear,
  input logic [1:0]        out_verdict
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_verdict == 2'd0));

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R7
  priv_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_rpl > seg_dpl) |=> out_verdict == 2'd3);

  // R8
  code_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seg_is_code && req_kind == 2'd1 && req_rpl <= seg_dpl)
      |=> out_verdict == 2'd2);

  // R9
  flat_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seg_is_code && seg_long && req_kind == 2'd2 &&
     req_rpl <= seg_dpl)
      |=> (out_verdict == 2'd0 && out_linear == $past(req_offset)));
endmodule

bind seg_guard seg_guard_chk #(
  .ADDR_W (ADDR_W),
  .LIM_W  (LIM_W),
  .LEN_W  (LEN_W),
  .PL_W   (PL_W),
  .SHORT_W(SHORT_W)
) chk_i (.*);

// File: tb/seg_guard_tb_top.sv
module seg_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] seg_base;
  logic [19:0] seg_limit;
  logic [1:0]  seg_dpl;
  logic        seg_is_code, seg_rw, seg_down, seg_gran, seg_def32, seg_long;
  logic [1:0]  req_rpl;
  logic [31:0] req_offset;
  logic [1:0]  req_len_m1;
  logic [1:0]  req_kind;
  logic        out_valid;
  logic [31:0] out_linear;
  logic [1:0]  out_verdict;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .seg_base(seg_base), .seg_limit(seg_limit), .seg_dpl(seg_dpl),
    .seg_is_code(seg_is_code), .seg_rw(seg_rw), .seg_down(seg_down),
    .seg_gran(seg_gran), .seg_def32(seg_def32), .seg_long(seg_long),
    .req_rpl(req_rpl), .req_offset(req_offset), .req_len_m1(req_len_m1),
    .req_kind(req_kind), .out_valid(out_valid), .out_linear(out_linear),
    .out_verdict(out_verdict)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic set_seg(input logic [31:0] base, input logic [19:0] lim,
                         input logic [1:0] dpl, input logic code,
                         input logic rw, input logic down, input logic g,
                         input logic d, input logic l);
    seg_base = base; seg_limit = lim; seg_dpl = dpl; seg_is_code = code;
    seg_rw = rw; seg_down = down; seg_gran = g; seg_def32 = d; seg_long = l;
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
  task automatic probe(input string tag, input logic [1:0] kind,
                       input logic [1:0] rpl, input logic [31:0] off,
                       input logic [1:0] len, input logic [1:0] exp_v,
                       input logic [31:0] exp_lin, input logic chk_lin);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_rpl = rpl;
    req_offset = off; req_len_m1 = len;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " verdict"}, {30'd0, out_verdict}, {30'd0, exp_v});
    if (chk_lin) check({tag, " linear"}, out_linear, exp_lin);
  endtask

  task automatic t_reset;
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset verdict", {30'd0, out_verdict}, 32'd0);
    check("R1 reset linear", out_linear, 32'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R1 idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_linear;
    set_seg(32'h0010_0000, 20'h000FF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R2 base+off", 2'd0, 2'd0, 32'h10, 2'd0, 2'd0, 32'h0010_0010, 1'b1);
    set_seg(32'h1234_5677, 20'h000FF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R2 odd base", 2'd1, 2'd0, 32'h5, 2'd0, 2'd0, 32'h1234_567C, 1'b1);
    set_seg(32'hFFFF_FFF0, 20'hFFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    probe("R2 wrap", 2'd0, 2'd0, 32'h20, 2'd0, 2'd0, 32'h0000_0010, 1'b1);
  endtask

  task automatic t_up_limit;
    set_seg(32'h0000_1000, 20'h000FF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R5 last at limit", 2'd0, 2'd0, 32'hFF, 2'd0, 2'd0, 32'h10FF, 1'b1);
    probe("R5 4B ending at limit", 2'd0, 2'd0, 32'hFC, 2'd3, 2'd0, 32'h10FC, 1'b1);
    probe("R5 4B straddle", 2'd0, 2'd0, 32'hFD, 2'd3, 2'd1, 32'h0, 1'b0);
    probe("R5 past limit", 2'd1, 2'd0, 32'h100, 2'd0, 2'd1, 32'h0, 1'b0);
  endtask

  task automatic t_gran;
    set_seg(32'h0, 20'h00001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    probe("R4 G=1 top", 2'd0, 2'd0, 32'h1FFF, 2'd0, 2'd0, 32'h1FFF, 1'b1);
    probe("R4 G=1 over", 2'd0, 2'd0, 32'h2000, 2'd0, 2'd1, 32'h0, 1'b0);
    set_seg(32'h0, 20'h00001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R4 G=0 over", 2'd0, 2'd0, 32'h2, 2'd0, 2'd1, 32'h0, 1'b0);
    set_seg(32'h0, 20'hFFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    probe("R5 carry out", 2'd0, 2'd0, 32'hFFFF_FFFE, 2'd3, 2'd1, 32'h0, 1'b0);
  endtask

  task automatic t_width;
    set_seg(32'h0000_4000, 20'h000FF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R3 D=0 masks high", 2'd0, 2'd0, 32'hABCD_0010, 2'd0, 2'd0, 32'h4010, 1'b1);
    set_seg(32'h0000_4000, 20'h000FF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R3 D=1 full", 2'd0, 2'd0, 32'hABCD_0010, 2'd0, 2'd1, 32'h0, 1'b0);
  endtask

  task automatic t_down;
    set_seg(32'h0, 20'h00FFF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    probe("R6 at limit", 2'd0, 2'd0, 32'h0FFF, 2'd0, 2'd1, 32'h0, 1'b0);
    probe("R6 limit+1", 2'd0, 2'd0, 32'h1000, 2'd0, 2'd0, 32'h1000, 1'b1);
    probe("R6 top 16", 2'd1, 2'd0, 32'hFFFE, 2'd1, 2'd0, 32'hFFFE, 1'b1);
    probe("R6 over 16", 2'd0, 2'd0, 32'hFFFF, 2'd1, 2'd1, 32'h0, 1'b0);
    set_seg(32'h0, 20'h00FFF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    probe("R6 D=1 above 16", 2'd0, 2'd0, 32'h0001_0000, 2'd0, 2'd0, 32'h0001_0000, 1'b1);
  endtask

  task automatic t_priv;
    set_seg(32'h0, 20'hFFFFF, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R7 equal", 2'd0, 2'd2, 32'h10, 2'd0, 2'd0, 32'h10, 1'b1);
    probe("R7 more priv", 2'd0, 2'd1, 32'h10, 2'd0, 2'd0, 32'h10, 1'b1);
    probe("R7 less priv", 2'd0, 2'd3, 32'h10, 2'd0, 2'd3, 32'h0, 1'b0);
  endtask

  task automatic t_type;
    set_seg(32'h0, 20'hFFFFF, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R8 code fetch", 2'd2, 2'd0, 32'h40, 2'd0, 2'd0, 32'h40, 1'b1);
    probe("R8 code read noread", 2'd0, 2'd0, 32'h40, 2'd0, 2'd2, 32'h0, 1'b0);
    probe("R8 code write", 2'd1, 2'd0, 32'h40, 2'd0, 2'd2, 32'h0, 1'b0);
    set_seg(32'h0, 20'hFFFFF, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R8 data write ro", 2'd1, 2'd0, 32'h40, 2'd0, 2'd2, 32'h0, 1'b0);
    probe("R8 data read ro", 2'd0, 2'd0, 32'h40, 2'd0, 2'd0, 32'h40, 1'b1);
    probe("R8 data fetch", 2'd2, 2'd0, 32'h40, 2'd0, 2'd2, 32'h0, 1'b0);
  endtask

  task automatic t_flat;
    set_seg(32'h5000_0000, 20'h00000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    probe("R9 flat fetch", 2'd2, 2'd0, 32'h8000_0000, 2'd3, 2'd0, 32'h8000_0000, 1'b1);
    set_seg(32'h5000_0000, 20'h00000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R9 non-flat limits", 2'd2, 2'd0, 32'h8000_0000, 2'd0, 2'd1, 32'h0, 1'b0);
    set_seg(32'h5000_0000, 20'h00000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    probe("R9 long on data", 2'd0, 2'd0, 32'h10, 2'd0, 2'd1, 32'h0, 1'b0);
  endtask

  task automatic t_prio;
    set_seg(32'h0, 20'h0000F, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R10 priv over all", 2'd1, 2'd3, 32'h100, 2'd0, 2'd3, 32'h0, 1'b0);
    probe("R10 type over limit", 2'd1, 2'd0, 32'h100, 2'd0, 2'd2, 32'h0, 1'b0);
    probe("R10 limit alone", 2'd2, 2'd0, 32'h100, 2'd0, 2'd1, 32'h0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_rpl = 2'd0;
    req_offset = '0; req_len_m1 = '0;
    set_seg(32'h0, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_linear();
    t_idle();
    t_up_limit();
    t_gran();
    t_width();
    t_down();
    t_priv();
    t_type();
    t_flat();
    t_prio();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule